// File: doc/BRIEF.md
# Dual-Count PWM Timer Channel

This block is a single timer channel that produces a pulse-width-modulated output from two separately programmed phase lengths. One reload value governs how long the output stays low, the other how long it stays high, both expressed in timer-clock cycles. A small register port lets software program the two reload values and a control word, read the running counter, observe and acknowledge a reload interrupt, and read a fixed revision code.

The counter runs down and, at the end of each phase, reloads from the register that belongs to the following phase. Two width rules are available. In the default rule a phase lasts one cycle more than its programmed value. In the exact rule a phase lasts exactly its programmed value, so a zero turns that phase off and gives a constant output (0% or 100% duty). With PWM disabled, the channel becomes a square-wave toggler driven by the low-phase value alone. In free-running mode, every phase lasts the full counter range.

The register port has no back-pressure. Every write or read is accepted in the cycle it is presented, and read data is combinational from the address. Software should clear enable, program both counts, write the control word, and then set enable.

Top module: `dct_pwm_timer`

## Requirements
- R1: After reset the output and interrupt are low, and the control word, both reload values and the counter all read as zero.
- R2: Register addresses: 0 control, 1 low reload, 2 high reload, 3 counter (read-only), 4 interrupt acknowledge, 5 interrupt status, 7 revision. Control bits: bit 0 enable, bit 1 user-defined mode (0 = free-running), bit 2 interrupt mask, bit 3 PWM, bit 4 exact-width rule. The control word reads back as written. The revision register reads 0x3231312A and ignores writes.
- R3: Setting enable loads the low reload value into the counter on the next cycle and holds the output low. With enable clear, the output is low and the counter holds its value.
- R4: In user-defined PWM mode with the default rule, the low phase lasts low+1 cycles and the high phase lasts high+1 cycles.
- R5: In user-defined PWM mode with the exact rule, the low phase lasts exactly low cycles and the high phase lasts exactly high cycles.
- R6: With the exact rule, a zero low value holds the output constantly high, and a zero high value holds it constantly low. The nonzero phase still reloads and raises the interrupt.
- R7: With the exact rule and both values zero, the output stays low and no reload interrupt is raised.
- R8: With PWM clear, the output toggles and each half lasts low+1 cycles. The high reload value and the exact-rule bit have no effect.
- R9: In free-running mode, every phase lasts 2^CW cycles regardless of the reload values.
- R10: A reload value written during a phase does not change the phase in progress. It takes effect at that value's next reload.
- R11: Each reload sets the interrupt status when the mask bit is clear and never when it is set. Reading address 4 returns the status in bit 0 and clears it. A reload in the same cycle as the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_rd | input | 1 | Read strobe (side effect only at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Reload interrupt status |

## Verification
The bench builds the channel with an 8-bit counter and a 32-bit register port. The narrow counter brings the free-running phase length of 256 cycles within a short run, so the 2^CW rule is measured directly. The 32-bit port still carries the full revision code. Phase widths are measured edge-to-edge for several low/high pairs under each width rule. The 0%, 100% and both-zero cases are observed over long windows, and a reload value is rewritten in the middle of a phase to show when it takes effect.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int CTRL_W = 5;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_LOW  = 3'd1;
  localparam logic [2:0] ADDR_HIGH = 3'd2;
  localparam logic [2:0] ADDR_CUR  = 3'd3;
  localparam logic [2:0] ADDR_EOI  = 3'd4;
  localparam logic [2:0] ADDR_STAT = 3'd5;
  localparam logic [2:0] ADDR_VER  = 3'd7;

  localparam logic [31:0] REVISION_CODE = 32'h3231312A;

  // packed MSB first: en lands on bit 0
  typedef struct packed {
    logic exact;
    logic pwm;
    logic mask;
    logic user;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  input  logic          reload,
  output ctrl_t         ctrl,
  output logic [CW-1:0] lo_load,
  output logic [CW-1:0] hi_load,
  output logic [DW-1:0] rdata,
  output logic          irq
);

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  logic ack;
  assign ack = rd && (addr == ADDR_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      lo_load <= '0;
      hi_load <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr) begin
        case (addr)
          ADDR_CTRL: ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
          ADDR_LOW:  lo_load <= wdata[CW-1:0];
          ADDR_HIGH: hi_load <= wdata[CW-1:0];
          default:   ;
        endcase
      end
      if (reload && !ctrl.mask) irq <= 1'b1;
      else if (ack)             irq <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = DW'({ctrl});
      ADDR_LOW:  rdata = DW'(lo_load);
      ADDR_HIGH: rdata = DW'(hi_load);
      ADDR_CUR:  rdata = DW'(cnt);
      ADDR_EOI:  rdata = DW'(irq);
      ADDR_STAT: rdata = DW'(irq);
      ADDR_VER:  rdata = DW'(REVISION_CODE);
      default:   rdata = '0;
    endcase
  end

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !reload) |=> !irq); // R11
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mask && !irq) |=> !irq); // R11

endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] lo_load,
  input  logic [CW-1:0] hi_load,
  output logic [CW-1:0] cnt,
  output logic          out,
  output logic          reload
);

  logic          en_d, phase_hi;
  logic [CW-1:0] cnt_n;
  logic          ph_n, out_n, rl_n;
  logic          free_run, exact_eff, lo_zero, hi_zero;
  logic          other_zero, cur_zero;
  logic [CW-1:0] other_load, cur_load;
  logic          unused_mask;

  assign unused_mask = ctrl.mask;

  assign free_run   = !ctrl.user;
  assign exact_eff  = ctrl.exact && ctrl.pwm && ctrl.user;
  assign lo_zero    = exact_eff && (lo_load == '0);
  assign hi_zero    = exact_eff && (hi_load == '0);
  assign other_zero = phase_hi ? lo_zero : hi_zero;
  assign cur_zero   = phase_hi ? hi_zero : lo_zero;
  assign other_load = phase_hi ? lo_load : hi_load;
  assign cur_load   = phase_hi ? hi_load : lo_load;

  // value placed in the counter so that the phase ends when it reaches zero
  function automatic logic [CW-1:0] load_of(input logic [CW-1:0] c,
                                            input logic fr, input logic ex);
    if (fr) return '1;
    if (ex) return c - CW'(1);
    return c;
  endfunction

  always_comb begin
    cnt_n = cnt;
    ph_n  = phase_hi;
    out_n = out;
    rl_n  = 1'b0;
    if (!ctrl.en) begin
      out_n = 1'b0;
      ph_n  = 1'b0;
    end else if (!en_d) begin
      if (lo_zero && !hi_zero) begin
        ph_n  = 1'b1;
        out_n = 1'b1;
        cnt_n = load_of(hi_load, free_run, exact_eff);
      end else begin
        ph_n  = 1'b0;
        out_n = 1'b0;
        cnt_n = lo_zero ? '0 : load_of(lo_load, free_run, exact_eff);
      end
    end else if (cnt != '0) begin
      cnt_n = cnt - CW'(1);
    end else if (!ctrl.pwm) begin
      ph_n  = 1'b0;
      out_n = !out;
      cnt_n = load_of(lo_load, free_run, 1'b0);
      rl_n  = 1'b1;
    end else if (!other_zero) begin
      ph_n  = !phase_hi;
      out_n = !phase_hi;
      cnt_n = load_of(other_load, free_run, exact_eff);
      rl_n  = 1'b1;
    end else if (!cur_zero) begin
      out_n = phase_hi;
      cnt_n = load_of(cur_load, free_run, exact_eff);
      rl_n  = 1'b1;
    end else begin
      ph_n  = 1'b0;
      out_n = 1'b0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d     <= 1'b0;
      phase_hi <= 1'b0;
      out      <= 1'b0;
      cnt      <= '0;
    end else begin
      en_d     <= ctrl.en;
      phase_hi <= ph_n;
      out      <= out_n;
      cnt      <= cnt_n;
    end
  end

  assign reload = rl_n;

  AST_OFF_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !out); // R3
  AST_OFF_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> $stable(cnt)); // R3
  AST_MIDPHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && en_d && cnt != '0) |=> $stable(out)); // R4

endmodule

// File: rtl/dct_pwm_timer.sv
module dct_pwm_timer
  import dct_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          pwm_out,
  output logic          irq
);

  ctrl_t         ctrl_w;
  logic [CW-1:0] lo_w, hi_w, cnt_w;
  logic          reload_w;

  dct_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cnt     (cnt_w),
    .reload  (reload_w),
    .ctrl    (ctrl_w),
    .lo_load (lo_w),
    .hi_load (hi_w),
    .rdata   (reg_rdata),
    .irq     (irq)
  );

  dct_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_w),
    .lo_load (lo_w),
    .hi_load (hi_w),
    .cnt     (cnt_w),
    .out     (pwm_out),
    .reload  (reload_w)
  );

  AST_BOTH_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w.en && ctrl_w.user && ctrl_w.pwm && ctrl_w.exact &&
     lo_w == '0 && hi_w == '0 && !irq) |=> !irq); // R7

endmodule

// File: tb/sim_dct_pwm_timer.sv
`timescale 1ns/1ps
module sim_dct_pwm_timer;
  localparam int CW = 8;
  localparam int DW = 32;
  localparam int EN = 1, USR = 2, MSK = 4, PWM = 8, EXA = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          pwm_out, irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dct_pwm_timer #(.CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int cbits, input int lo, input int hi);
    bus_wr(3'd0, 0);
    bus_wr(3'd1, DW'(lo));
    bus_wr(3'd2, DW'(hi));
    bus_wr(3'd0, DW'(cbits));
    bus_wr(3'd0, DW'(cbits | EN));
  endtask

  task automatic wait_level(input logic v);
    for (int i = 0; i < 2000 && pwm_out !== v; i++) @(negedge clk);
  endtask

  task automatic measure(output int lo_len, output int hi_len);
    int n;
    wait_level(1'b0);
    wait_level(1'b1);
    n = 0;
    while (pwm_out === 1'b1 && n < 2000) begin n++; @(negedge clk); end
    hi_len = n;
    n = 0;
    while (pwm_out === 1'b0 && n < 2000) begin n++; @(negedge clk); end
    lo_len = n;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk(pwm_out === 1'b0, "R1 out", pwm_out, 0);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    peek(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    peek(3'd1, d); chk(d == 0, "R1 low", d, 0);
    peek(3'd3, d); chk(d == 0, "R1 counter", d, 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] d;
    bus_wr(3'd0, 32'h1E);
    bus_rd(3'd0, d); chk(d == 32'h1E, "R2 ctrl readback", d, 32'h1E);
    bus_wr(3'd7, 32'h0);
    bus_rd(3'd7, d); chk(d == 32'h3231312A, "R2 revision", d, 32'h3231312A);
    bus_wr(3'd0, 0);
  endtask

  task automatic t_start_stop();
    logic [DW-1:0] a, b;
    bus_wr(3'd1, 7);
    bus_wr(3'd2, 9);
    bus_wr(3'd0, USR | PWM | MSK);
    bus_wr(3'd0, USR | PWM | MSK | EN);
    bus_rd(3'd3, a);
    chk(a == 7, "R3 load on enable", a, 7);
    chk(pwm_out === 1'b0, "R3 out low at start", pwm_out, 0);
    repeat (12) @(negedge clk);
    bus_wr(3'd0, USR | PWM | MSK);
    repeat (5) @(negedge clk);
    peek(3'd3, a);
    chk(pwm_out === 1'b0, "R3 out low when off", pwm_out, 0);
    repeat (6) @(negedge clk);
    peek(3'd3, b);
    chk(a == b, "R3 counter frozen", b, a);
  endtask

  task automatic t_normal();
    int l, h;
    setup(USR | PWM, 3, 5);
    measure(l, h);
    chk(l == 4, "R4 low 3", l, 4);
    chk(h == 6, "R4 high 5", h, 6);
    setup(USR | PWM, 0, 2);
    measure(l, h);
    chk(l == 1, "R4 low 0", l, 1);
    chk(h == 3, "R4 high 2", h, 3);
  endtask

  task automatic t_exact();
    int l, h;
    setup(USR | PWM | EXA, 3, 5);
    measure(l, h);
    chk(l == 3, "R5 low 3", l, 3);
    chk(h == 5, "R5 high 5", h, 5);
    setup(USR | PWM | EXA, 1, 1);
    measure(l, h);
    chk(l == 1, "R5 low 1", l, 1);
    chk(h == 1, "R5 high 1", h, 1);
  endtask

  task automatic t_full_empty();
    int bad;
    logic [DW-1:0] d;
    setup(USR | PWM | EXA, 0, 4);
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 24; i++) begin if (pwm_out !== 1'b1) bad++; @(negedge clk); end
    chk(bad == 0, "R6 constant high", bad, 0);
    setup(USR | PWM | EXA, 4, 0);
    repeat (3) @(negedge clk);
    bus_rd(3'd4, d);
    bad = 0;
    for (int i = 0; i < 24; i++) begin if (pwm_out !== 1'b0) bad++; @(negedge clk); end
    chk(bad == 0, "R6 constant low", bad, 0);
    chk(irq === 1'b1, "R6 reload irq at 0%", irq, 1);
  endtask

  task automatic t_both_zero();
    int bad;
    logic [DW-1:0] d;
    setup(USR | PWM | EXA, 0, 0);
    repeat (3) @(negedge clk);
    bus_rd(3'd4, d);
    bad = 0;
    for (int i = 0; i < 24; i++) begin if (pwm_out !== 1'b0) bad++; @(negedge clk); end
    chk(bad == 0, "R7 output low", bad, 0);
    chk(irq === 1'b0, "R7 no irq", irq, 0);
  endtask

  task automatic t_toggle();
    int l, h;
    setup(USR | EXA, 2, 9);
    measure(l, h);
    chk(l == 3, "R8 toggle low half", l, 3);
    chk(h == 3, "R8 toggle high half", h, 3);
  endtask

  task automatic t_free();
    int l, h;
    setup(PWM, 3, 5);
    measure(l, h);
    chk(l == 256, "R9 free low", l, 256);
    chk(h == 256, "R9 free high", h, 256);
  endtask

  task automatic t_midphase();
    int n, l, h;
    setup(USR | PWM, 20, 20);
    wait_level(1'b0);
    wait_level(1'b1);
    n = 0;
    while (pwm_out === 1'b1 && n < 2000) begin
      reg_wr = (n == 1); reg_addr = 3'd2; reg_wdata = 6;
      n++;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk(n == 21, "R10 current high unchanged", n, 21);
    l = 0;
    while (pwm_out === 1'b0 && l < 2000) begin l++; @(negedge clk); end
    chk(l == 21, "R10 low unchanged", l, 21);
    h = 0;
    while (pwm_out === 1'b1 && h < 2000) begin h++; @(negedge clk); end
    chk(h == 7, "R10 new high after reload", h, 7);
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    setup(USR | PWM | MSK, 30, 30);
    bus_rd(3'd4, d);
    repeat (70) @(negedge clk);
    chk(irq === 1'b0, "R11 masked irq", irq, 0);
    bus_rd(3'd5, d);
    chk(d == 0, "R11 masked status", d, 0);
    bus_wr(3'd0, USR | PWM | EN);
    repeat (70) @(negedge clk);
    chk(irq === 1'b1, "R11 irq set", irq, 1);
    wait_level(1'b0);
    wait_level(1'b1);
    bus_rd(3'd4, d);
    chk(d == 1, "R11 ack returns status", d, 1);
    chk(irq === 1'b0, "R11 ack clears", irq, 0);
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_start_stop();
    t_normal();
    t_exact();
    t_full_empty();
    t_both_zero();
    t_toggle();
    t_free();
    t_midphase();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule